// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter assembled from identical 4-bit slices. Each slice holds a nibble of the count and can be preset in parallel from a data bus. It has an active-low clear and an active-low load, and it counts only when two active-high enables are both asserted. The first enable, `en_par`, goes to every slice. The second enable, `en_trk`, also gates the slice's terminal-count carry.

The top level chains `STAGES` slices into one counter that is `STAGES*4` bits wide. The carry out of each slice drives the trickle enable of the slice above it. The upper slice therefore advances on the same clock edge on which the lower slice rolls over from all ones to zero.

The parameter `CLR_MODE` sets the clear at build time:
- In `CLR_ASYNC` mode, the clear acts at once, without a clock edge.
- In `CLR_SYNC` mode, the clear acts on the next rising edge.

The block has no data stream, so no interface on it uses valid/ready handshaking. Every pin is a plain control or data pin.

Top module: `cnt_chain`

## Requirements
- R1: When `load_n` is low at a rising edge and `clr_n` is high, `q` takes the value of `din`, whatever the enables are.
- R2: When `clr_n`, `load_n`, `en_par` and `en_trk` are all high at a rising edge, `q` increases by one, modulo 2^(4*STAGES).
- R3: When `load_n` is high and either `en_par` or `en_trk` is low at a rising edge, `q` keeps its value.
- R4: In `CLR_ASYNC` mode, driving `clr_n` low forces `q` to zero at once, without waiting for a clock edge. `q` stays at zero while `clr_n` is low.
- R5: In `CLR_SYNC` mode, `q` becomes zero on a rising edge at which `clr_n` is low. Between edges, a low `clr_n` leaves `q` unchanged.
- R6: Clear has priority over load, and load has priority over counting.
- R7: `carry_out` is high exactly when `q` is all ones and `en_trk` is high. `en_par` has no effect on `carry_out`.
- R8: Slice k holds `q[4k+3:4k]`. The carry of slice k is the trickle enable of slice k+1. A count from 0x0F gives 0x10 on one edge, and a count from all ones gives zero.
- R9: This sequence is reproduced on the low nibble: clear to 0, load 12, count 13, 14, 15, 0, 1, 2, then hold while counting is inhibited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous, set by `CLR_MODE` |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Parallel count enable, shared by all slices |
| en_trk | input | 1 | Trickle count enable into slice 0; also gates `carry_out` |
| din | input | 4*STAGES | Preset value |
| q | output | 4*STAGES | Current count |
| carry_out | output | 1 | Terminal-count carry of the top slice |

## Verification
A slice register that takes a wrong value shows up on `q` at the first sample after the edge that caused it. A broken carry path between slices shows up one edge later: the upper nibble fails to advance, or advances, on the step from 0x0F. The bench runs both clear variants side by side on the same stimulus. This makes a gap between the immediate clear and the edge-timed clear visible in the middle of the cycle where the clear is asserted, before the next edge.

// File: rtl/cnt_chain_pkg.sv
package cnt_chain_pkg;
  localparam int SLICE_W = 4;

  typedef enum logic {
    CLR_ASYNC = 1'b0,
    CLR_SYNC  = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_chain_pkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  output logic [W-1:0] nxt
);
  // load beats counting; counting needs both enables
  always_comb begin
    if (!load_n)                nxt = din;
    else if (en_par && en_trk)  nxt = cur + W'(1);
    else                        nxt = cur;
  end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_chain_pkg::*;
#(
  parameter int        W        = SLICE_W,
  parameter clr_mode_e CLR_MODE = CLR_ASYNC
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         rc
);
  logic [W-1:0] nxt;

  cnt_next #(.W(W)) u_next (
    .cur(q), .din(din), .load_n(load_n),
    .en_par(en_par), .en_trk(en_trk), .nxt(nxt)
  );

  generate
    if (CLR_MODE == CLR_ASYNC) begin : g_aclr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sclr
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate

  // terminal count, qualified only by the trickle enable
  assign rc = (&q) & en_trk;

  assert_load_R1: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));
  assert_count_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk) |=> q == W'($past(q) + W'(1)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_trk)) |=> $stable(q));
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cnt_chain_pkg::*;
#(
  parameter int        STAGES   = 2,
  parameter clr_mode_e CLR_MODE = CLR_ASYNC,
  localparam int       TOT_W    = STAGES * SLICE_W
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [TOT_W-1:0] din,
  output logic [TOT_W-1:0] q,
  output logic             carry_out
);
  logic [STAGES:0] trk;

  assign trk[0] = en_trk;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      cnt_slice #(.W(SLICE_W), .CLR_MODE(CLR_MODE)) u_slice (
        .clk(clk),
        .clr_n(clr_n),
        .load_n(load_n),
        .en_par(en_par),
        .en_trk(trk[k]),
        .din(din[k*SLICE_W +: SLICE_W]),
        .q(q[k*SLICE_W +: SLICE_W]),
        .rc(trk[k+1])
      );
    end
  endgenerate

  assign carry_out = trk[STAGES];

  assert_carry_R7: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out == ((&q) && en_trk));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk && (&q)) |=> q == '0);
  assert_nibble_R8: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk && q[SLICE_W-1:0] == '1 && q != '1)
      |=> q == TOT_W'($past(q) + TOT_W'(1)));
endmodule

// File: tb/test_cnt_chain.sv
module test_cnt_chain;
  import cnt_chain_pkg::*;
  localparam int STAGES = 2;
  localparam int TW     = STAGES * SLICE_W;
  localparam int MAXV   = (1 << TW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          clr_n, load_n, en_par, en_trk;
  logic [TW-1:0] din;
  logic [TW-1:0] q_a, q_s;
  logic          c_a, c_s;

  cnt_chain #(.STAGES(STAGES), .CLR_MODE(CLR_ASYNC)) i_cnt_chain (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din), .q(q_a), .carry_out(c_a));

  cnt_chain #(.STAGES(STAGES), .CLR_MODE(CLR_SYNC)) i_cnt_chain_sync (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din), .q(q_s), .carry_out(c_s));

  int ma, ms;
  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk({req, " q async"},  32'(q_a), 32'(ma));
    chk({req, " q sync"},   32'(q_s), 32'(ms));
    chk({req, " carry async"}, 32'(c_a), 32'((ma == MAXV) && en_trk));
    chk({req, " carry sync"},  32'(c_s), 32'((ms == MAXV) && en_trk));
  endtask

  task automatic apply(bit cl, bit ld, bit ep, bit et, int d, string req);
    clr_n = cl; load_n = ld; en_par = ep; en_trk = et; din = TW'(d);
    @(posedge clk);
    if (!cl) begin
      ma = 0; ms = 0;
    end else if (!ld) begin
      ma = d & MAXV; ms = d & MAXV;
    end else if (ep && et) begin
      ma = (ma + 1) & MAXV; ms = (ms + 1) & MAXV;
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    clr_n = 1'b0; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0; din = '0;
    ma = 0; ms = 0;
    @(negedge clk);
    // R9 reference sequence: clear, preset 12, count, inhibit
    apply(0, 1, 1, 1, 0, "R9 clear");
    apply(1, 0, 0, 0, 12, "R9 preset");
    for (int k = 1; k <= 6; k++) begin
      apply(1, 1, 1, 1, 0, "R9 count");
      chk("R9 low nibble", 32'(q_a[3:0]), 32'((12 + k) % 16));
    end
    apply(1, 1, 0, 1, 0, "R9 inhibit");
    chk("R9 hold nibble", 32'(q_a[3:0]), 32'd2);
    // R3 hold with each enable low
    apply(1, 1, 1, 0, 0, "R3 trk low");
    apply(1, 1, 0, 0, 0, "R3 both low");
    // R1 load ignores enables
    apply(1, 0, 1, 1, 8'hA7, "R1 load en high");
    apply(1, 0, 0, 1, 8'h3C, "R1 load en low");
    // R8 nibble carry 0x0F -> 0x10
    apply(1, 0, 0, 0, 8'h0F, "R8 preset 0F");
    apply(1, 1, 1, 1, 0, "R8 step to 10");
    chk("R8 upper nibble", 32'(q_a[7:4]), 32'd1);
    // R7 carry at all ones, en_par irrelevant, en_trk gates
    apply(1, 0, 0, 0, 8'hFE, "R2 preset FE");
    apply(1, 1, 1, 1, 0, "R2 step to FF");
    chk("R7 carry at FF", 32'(c_a), 32'd1);
    apply(1, 1, 0, 1, 0, "R7 en_par low carry");
    chk("R7 carry with en_par low", 32'(c_s), 32'd1);
    apply(1, 1, 1, 0, 0, "R7 en_trk low");
    chk("R7 carry gated", 32'(c_a), 32'd0);
    apply(1, 1, 1, 1, 0, "R8 wrap FF to 00");
    chk("R8 wrap", 32'(q_a), 32'd0);
    // R6 clear beats load, load beats count
    apply(1, 0, 0, 0, 8'h44, "R6 setup");
    apply(0, 0, 1, 1, 8'h99, "R6 clear over load");
    apply(1, 0, 1, 1, 8'h21, "R6 load over count");
    chk("R6 load value", 32'(q_s), 32'h21);
    // R4/R5 clear asserted between edges
    apply(1, 0, 0, 0, 8'h55, "R4 setup");
    #2 clr_n = 1'b0;
    #1 ma = 0;
    chk("R4 immediate clear", 32'(q_a), 32'd0);
    chk("R5 no clear before edge", 32'(q_s), 32'h55);
    apply(0, 1, 1, 1, 0, "R5 clear at edge");
    apply(0, 1, 1, 1, 0, "R4 held low");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      apply(((r & 31) != 0), ((r >> 5) & 7) != 0, ((r >> 8) & 3) != 0,
            ((r >> 10) & 3) != 0, (r >> 12) & MAXV, "R2 mixed");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule